// File: doc/BRIEF.md
# Constrained Event-to-Counter Allocator

This block hands out hardware event counters from a bank of ten. A requester presents an 8-bit event code. A fixed affinity decoder turns that code into the set of counters that are able to count that event. Most codes can use any of counters 2 to 9. A few codes are pinned to a single counter, and others are limited to a small group such as the even counters 2, 4 and 6.

The allocator keeps a mask of counters that are in use. It removes the busy counters from the allowed set and grants the lowest-numbered counter that remains. In the same clock edge it marks that counter busy. If no allowed counter is free, it raises a fail strobe and allocates nothing. A separate release port frees a counter by its index.

Allocation is greedy, one request per cycle. The block does not attempt to place the most constrained events first.

Top module: `ctr_alloc`

## Requirements
- R1: After reset, no counter is in use and neither grant_o nor fail_o is asserted.
- R2: Any event code not named in R3 to R6 may use counters 2 through 9 only. Examples are 0x00, 0x10 and 0x55.
- R3: Code 0x02 may use counter 0 or counters 2 through 9. Code 0x8C may use only counters 1 and 7.
- R4: Codes 0x01, 0x97, 0x9A and 0x9F may use only counter 7.
- R5: Codes 0x8D-0x90, 0x93-0x96, 0x98, 0x99, 0x9B, 0x9C, 0xBF, 0xC0, 0xC1, 0xC4-0xC6, 0xC8, 0xCA and 0xCB may use only counters 5, 6 and 7.
- R6: Codes 0xF5, 0xF6, 0xF7 and 0xFD may use only counters 2, 4 and 6. Code 0xF8 may use counters 2 through 7.
- R7: A request grants the lowest-indexed counter that is both allowed and free. That counter is marked in use at the same clock edge, so the next request cannot receive it.
- R8: If every allowed counter is in use, the request produces fail_o and the in-use mask is left unchanged.
- R9: A release with an index from 0 to 9 frees that counter, and a later request can receive it. A release with an index of 10 or more has no effect.
- R10: When a release and a request arrive in the same cycle, both take effect. The request still sees the counter as in use; the freed counter can be granted from the next cycle.
- R11: grant_o and fail_o are one-cycle strobes that are never asserted together. Each appears exactly one cycle after the request is captured. idx_o carries the granted index while grant_o is high and reads 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Allocation request, sampled at each rising edge |
| code_i | input | 8 | Event code of the request |
| rel_i | input | 1 | Release request |
| rel_idx_i | input | 4 | Index of the counter to release |
| grant_o | output | 1 | Allocation succeeded (one-cycle strobe) |
| fail_o | output | 1 | No allowed counter was free (one-cycle strobe) |
| idx_o | output | 4 | Granted counter index, valid with grant_o |

## Verification
A request captured at one rising edge produces its grant or fail strobe, together with its index, at the very next edge. The driver therefore pushes one expected result per cycle it drives. The monitor pops that result 2 ns after the following edge, clear of both clock edges.

A release changes only what later requests see. A release issued alongside a request therefore shows up in the result expected for the request in the next cycle, not in the current one. An out-of-range release is checked by observing that a later request still fails. Idle cycles are queued as results with no strobe, which confirms that each strobe lasts exactly one cycle.

// File: rtl/ctr_alloc_pkg.sv
package ctr_alloc_pkg;
  localparam int NUM_CTRS = 10;
  localparam int CODE_W   = 8;
  localparam int IDX_W    = $clog2(NUM_CTRS);
  typedef logic [NUM_CTRS-1:0] ctr_mask_t;

  // common affinity groups, counter bit positions are behaviour
  localparam ctr_mask_t MASK_GENERAL = ctr_mask_t'(10'b11_1111_1100);
  localparam ctr_mask_t MASK_C7      = ctr_mask_t'(10'b00_1000_0000);
  localparam ctr_mask_t MASK_C567    = ctr_mask_t'(10'b00_1110_0000);
  localparam ctr_mask_t MASK_EVEN    = ctr_mask_t'(10'b00_0101_0100);
  localparam ctr_mask_t MASK_C2TO7   = ctr_mask_t'(10'b00_1111_1100);
  localparam ctr_mask_t MASK_CYC     = ctr_mask_t'(10'b11_1111_1101);
  localparam ctr_mask_t MASK_INSN    = ctr_mask_t'(10'b00_1000_0010);
endpackage

// File: rtl/ctr_affinity_dec.sv
module ctr_affinity_dec
  import ctr_alloc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output ctr_mask_t         allow_o
);
  always_comb begin
    case (code_i) inside
      8'h02:                                   allow_o = MASK_CYC;
      8'h8C:                                   allow_o = MASK_INSN;
      8'h01, 8'h97, 8'h9A, 8'h9F:              allow_o = MASK_C7;
      [8'h8D:8'h90], [8'h93:8'h96], 8'h98, 8'h99,
      8'h9B, 8'h9C, 8'hBF, 8'hC0, 8'hC1,
      [8'hC4:8'hC6], 8'hC8, 8'hCA, 8'hCB:      allow_o = MASK_C567;
      8'hF5, 8'hF6, 8'hF7, 8'hFD:              allow_o = MASK_EVEN;
      8'hF8:                                   allow_o = MASK_C2TO7;
      default:                                 allow_o = MASK_GENERAL;
    endcase
  end

  // every code must map to a non-empty set (R2)
  always_comb begin
    assert_allow_nonempty_R2: assert (allow_o != '0) else $error("empty affinity");
  end
endmodule

// File: rtl/ctr_pick_lowest.sv
module ctr_pick_lowest #(
  parameter int W  = 10,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  cand_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  logic [W-1:0] below;
  logic [W-1:0] first;

  assign below[0] = 1'b0;
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign below[i] = below[i-1] | cand_i[i-1];
  end
  assign first   = cand_i & ~below;
  assign found_o = |cand_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++)
      if (first[i]) idx_o = idx_o | IW'(i);
  end

  // pick is a candidate and nothing lower is (R7)
  always_comb begin
    if (found_o) begin
      assert_pick_member_R7: assert (cand_i[idx_o]) else $error("pick not a candidate");
    end
  end
endmodule

// File: rtl/ctr_use_tracker.sv
module ctr_use_tracker #(
  parameter int W  = 10,
  parameter int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_en_i,
  input  logic [IW-1:0] set_idx_i,
  input  logic          clr_en_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [W-1:0]  used_o
);
  logic [W-1:0] used_q, set_m, clr_m;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    for (int i = 0; i < W; i++) begin
      if (set_en_i && set_idx_i == IW'(i)) set_m[i] = 1'b1;
      if (clr_en_i && clr_idx_i == IW'(i)) clr_m[i] = 1'b1;
    end
  end

  // set wins: a counter freed and regranted in one cycle stays used
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) used_q <= '0;
    else         used_q <= (used_q & ~clr_m) | set_m;
  end

  assign used_o = used_q;

  assert_release_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i && int'(clr_idx_i) < W && !(set_en_i && set_idx_i == clr_idx_i)
    |=> !used_q[$past(clr_idx_i)]);

  assert_set_marks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> used_q[$past(set_idx_i)]);

  assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_en_i && !clr_en_i |=> $stable(used_q));
endmodule

// File: rtl/ctr_alloc.sv
module ctr_alloc
  import ctr_alloc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rel_i,
  input  logic [IDX_W-1:0]  rel_idx_i,
  output logic              grant_o,
  output logic              fail_o,
  output logic [IDX_W-1:0]  idx_o
);
  ctr_mask_t        allow, used, avail;
  logic             found;
  logic [IDX_W-1:0] pick;
  logic             take;

  ctr_affinity_dec u_dec (.code_i(code_i), .allow_o(allow));

  assign avail = allow & ~used;

  ctr_pick_lowest #(.W(NUM_CTRS), .IW(IDX_W)) u_pick (
    .cand_i(avail), .found_o(found), .idx_o(pick)
  );

  assign take = req_i & found;

  ctr_use_tracker #(.W(NUM_CTRS), .IW(IDX_W)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_en_i(take), .set_idx_i(pick),
    .clr_en_i(rel_i), .clr_idx_i(rel_idx_i),
    .used_o(used)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= 1'b0;
      fail_o  <= 1'b0;
      idx_o   <= '0;
    end else begin
      grant_o <= take;
      fail_o  <= req_i & ~found;
      idx_o   <= take ? pick : '0;
    end
  end

  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && fail_o));

  assert_strobe_follows_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o || fail_o) |-> $past(req_i));

  assert_grant_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> int'(idx_o) < NUM_CTRS && used[idx_o]);

  assert_fail_keeps_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !$past(rel_i) |-> used == $past(used));

  assert_idx_zero_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_o |-> idx_o == '0);
endmodule

// File: tb/ctr_alloc_bench.sv
module ctr_alloc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, rel = 1'b0;
  logic [7:0] code = '0;
  logic [3:0] rel_idx = '0;
  logic       grant, fail;
  logic [3:0] idx;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic       g;
    logic       f;
    logic [3:0] i;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [9:0] model_used = '0;

  always #4 clk = ~clk;

  ctr_alloc u_ctr_alloc (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .code_i(code),
    .rel_i(rel), .rel_idx_i(rel_idx),
    .grant_o(grant), .fail_o(fail), .idx_o(idx)
  );

  function automatic logic [9:0] allowed(input logic [7:0] c);
    if (c == 8'h02) return 10'h3FD;
    if (c == 8'h8C) return 10'h082;
    if (c inside {8'h01, 8'h97, 8'h9A, 8'h9F}) return 10'h080;
    if (c inside {8'hF5, 8'hF6, 8'hF7, 8'hFD}) return 10'h054;
    if (c == 8'hF8) return 10'h0FC;
    if ((c >= 8'h8D && c <= 8'h90) || (c >= 8'h93 && c <= 8'h96) ||
        (c >= 8'hC4 && c <= 8'hC6) ||
        c inside {8'h98, 8'h99, 8'h9B, 8'h9C, 8'hBF, 8'hC0, 8'hC1, 8'hC8, 8'hCA, 8'hCB})
      return 10'h0E0;
    return 10'h3FC;
  endfunction

  // driver: one cycle of stimulus, expected result queued for the monitor
  task automatic op(input logic r, input logic [7:0] c, input logic rl,
                    input logic [3:0] ri, input string tag);
    exp_t e;
    logic [9:0] av;
    @(negedge clk);
    req = r; code = c; rel = rl; rel_idx = ri;
    e.g = 0; e.f = 0; e.i = '0; e.tag = tag;
    if (r) begin
      av = allowed(c) & ~model_used;
      e.f = (av == '0);
      for (int k = 9; k >= 0; k--)
        if (av[k]) begin e.g = 1; e.i = 4'(k); end
    end
    q.push_back(e);
    if (rl && ri < 10) model_used[ri] = 1'b0;
    if (e.g) model_used[e.i] = 1'b1;
  endtask

  // monitor: results are due one edge after capture, sampled 2 ns later
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (grant !== e.g || fail !== e.f || idx !== e.i) begin
          errors++;
          $display("FAIL %s: got g=%0b f=%0b i=%0d exp g=%0b f=%0b i=%0d",
                   e.tag, grant, fail, idx, e.g, e.f, e.i);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (grant !== 0 || fail !== 0 || idx !== 0) begin
      errors++;
      $display("FAIL R1: got g=%0b f=%0b i=%0d exp 0 0 0", grant, fail, idx);
    end
    op(1, 8'h02, 0, 0, "R3 cycles to c0");
    op(1, 8'h02, 0, 0, "R7 cycles next c2");
    op(1, 8'h00, 0, 0, "R2 default c3");
    op(1, 8'h55, 0, 0, "R2 default c4");
    op(0, 8'h00, 0, 0, "R11 idle no strobe");
    op(1, 8'h8C, 0, 0, "R3 insn c1");
    op(1, 8'h8C, 0, 0, "R3 insn c7");
    op(1, 8'h8C, 0, 0, "R8 insn full");
    op(1, 8'h01, 0, 0, "R4 c7 busy fail");
    op(1, 8'h8D, 0, 0, "R5 group c5");
    op(1, 8'hC4, 0, 0, "R5 group c6");
    op(1, 8'hCB, 0, 0, "R5 group full");
    op(0, 8'h00, 1, 4'd7, "R9 release c7");
    op(1, 8'h97, 0, 0, "R4 regrant c7");
    op(0, 8'h00, 1, 4'd4, "R9 release c4");
    op(1, 8'hF5, 0, 0, "R6 even c4");
    op(1, 8'hFD, 0, 0, "R6 even full");
    op(1, 8'hF8, 0, 0, "R6 c2to7 full");
    op(1, 8'h10, 0, 0, "R2 default c8");
    op(1, 8'h10, 0, 0, "R2 default c9");
    op(1, 8'h10, 0, 0, "R8 default full");
    op(1, 8'h10, 1, 4'd9, "R10 same-cycle release not seen");
    op(1, 8'h10, 0, 0, "R10 freed c9 next cycle");
    op(0, 8'h00, 1, 4'd12, "R9 out-of-range release");
    op(1, 8'h02, 0, 0, "R9 still full after bad release");
    op(0, 8'h00, 1, 4'd0, "R9 release c0");
    op(1, 8'h02, 0, 0, "R3 cycles back to c0");
    op(0, 8'h00, 1, 4'd6, "R9 release c6");
    op(0, 8'h00, 1, 4'd2, "R9 release c2");
    op(1, 8'hF8, 0, 0, "R6 c2to7 c2");
    op(1, 8'h9F, 0, 0, "R4 c7 only busy");
    op(1, 8'h90, 0, 0, "R5 group c6");
    op(0, 8'h00, 0, 0, "R11 idle");
    @(negedge clk);
    req = 0; rel = 0;
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d results never observed, exp 0", q.size());
    end
    finish_run();
  end
endmodule